// File: doc/BRIEF.md
# Dual-Strobe Reversible Counter Stage

A 4-bit presettable counter driven by two separate count strobes, one that counts up and one that counts down. Both strobes are sampled on a free-running system clock, passed through a synchronizer, and turned into rising-edge events. A rise on one strobe counts only while the other strobe is held high. All state bits are held in one register, so every output bit changes on the same clock edge. A parameter selects modulo-16 binary or modulo-10 decimal counting.

An active-high clear and an active-low parallel load override counting. The counter also drives two active-low cascade flags. The carry flag is low while the count is at or above its top value and the up strobe is low. The borrow flag is low while the count is zero and the down strobe is low. Each flag therefore copies the low phase of the strobe that will cause the wrap. Connecting carry to the next stage's up strobe and borrow to the next stage's down strobe forms a wider counter with no extra logic.

Top module: `updown_strobe_counter`

## Requirements
- R1: A synchronized rise of `up_strobe` while `dn_strobe` is high raises `q` by one. In binary mode (BCD=0) the top value is 15; in decimal mode (BCD=1) it is 9. Counting up from any value at or above the top value gives 0.
- R2: A synchronized rise of `dn_strobe` while `up_strobe` is high lowers `q` by one. Counting down from 0 gives the top value. Counting down from a loaded value above 9 in decimal mode lowers it by one.
- R3: These events leave `q` unchanged: a rise of one strobe while the other is low, a rise of both strobes in the same cycle, and clock cycles with no rise.
- R4: While `clear` is low and `load_n` is low, `q` takes the value of `din` at the next clock edge. Any value 0..15 is accepted in either mode, and strobe edges have no effect while `load_n` is low.
- R5: `clear` high sets `q` to 0 at the next clock edge. This holds whatever the state of `load_n` and the strobes.
- R6: `carry_n` is low exactly while `q` is at or above the top value and the synchronized `up_strobe` is low. Its low phase is as many clock cycles long as the low phase of `up_strobe`.
- R7: `borrow_n` is low exactly while `q` is 0 and the synchronized `dn_strobe` is low. Its low phase is as many clock cycles long as the low phase of `dn_strobe`.
- R8: A strobe rise applied between clock edges changes `q` on the third rising clock edge after it.
- R9: Two stages joined carry-to-up and borrow-to-down count as one counter over 8 bits: modulo 256 in binary mode and 0..99 in decimal mode, in both directions.
- R10: `rst` high at a clock edge sets `q` to 0 and the synchronizers to the idle-high level. After reset, `carry_n` and `borrow_n` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples everything |
| rst | input | 1 | Synchronous reset, active high |
| up_strobe | input | 1 | Count-up strobe, counts on its rising edge |
| dn_strobe | input | 1 | Count-down strobe, counts on its rising edge |
| load_n | input | 1 | Parallel load, active low |
| clear | input | 1 | Clear to zero, active high |
| din | input | 4 | Preset value |
| q | output | 4 | Count value |
| carry_n | output | 1 | Overflow flag, active low |
| borrow_n | output | 1 | Underflow flag, active low |

## Verification
The checker watches these rules on every cycle:
- clear and load reach `q` one clock edge later;
- each detected count event moves `q` by exactly one step in its direction;
- `q` holds when there is no event;
- a cascade flag never goes low while its own strobe is at the synchronized high level.

Some behaviours show only in the bench's scenarios: the three-edge latency from pin to count, the exact length of the carry and borrow low phases, the effect of a rise while the other strobe is low, and the two-stage counts across 8 bits. These run in both modes, with sweeps over every load value.

// File: rtl/updn_pkg.sv
`timescale 1ns/1ps
package updn_pkg;
  localparam int CNT_W = 4;
  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t top_value(input bit bcd);
    return bcd ? cnt_t'(9) : cnt_t'(15);
  endfunction

  function automatic cnt_t step_up(input cnt_t v, input bit bcd);
    return (v >= top_value(bcd)) ? cnt_t'(0) : cnt_t'(v + cnt_t'(1));
  endfunction

  function automatic cnt_t step_down(input cnt_t v, input bit bcd);
    return (v == cnt_t'(0)) ? top_value(bcd) : cnt_t'(v - cnt_t'(1));
  endfunction
endpackage

// File: rtl/strobe_sync.sv
`timescale 1ns/1ps
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= strobe_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], strobe_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/count_core.sv
`timescale 1ns/1ps
module count_core
  import updn_pkg::*;
#(
  parameter bit BCD = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic load_n,
  input  cnt_t din,
  input  logic inc,
  input  logic dec,
  output cnt_t q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (clear)   q <= '0;
    else if (!load_n) q <= din;
    else if (inc)     q <= step_up(q, BCD);
    else if (dec)     q <= step_down(q, BCD);
  end
endmodule

// File: rtl/cascade_flags.sv
`timescale 1ns/1ps
module cascade_flags
  import updn_pkg::*;
#(
  parameter bit BCD = 1'b0
) (
  input  cnt_t q,
  input  logic up_lvl,
  input  logic dn_lvl,
  output logic carry_n,
  output logic borrow_n
);
  logic at_top;
  logic at_zero;
  assign at_top   = (q >= top_value(BCD));
  assign at_zero  = (q == cnt_t'(0));
  assign carry_n  = ~(at_top & ~up_lvl);
  assign borrow_n = ~(at_zero & ~dn_lvl);
endmodule

// File: rtl/updown_strobe_counter.sv
`timescale 1ns/1ps
module updown_strobe_counter
  import updn_pkg::*;
#(
  parameter bit BCD         = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       up_strobe,
  input  logic       dn_strobe,
  input  logic       load_n,
  input  logic       clear,
  input  logic [3:0] din,
  output logic [3:0] q,
  output logic       carry_n,
  output logic       borrow_n
);
  logic up_lvl, up_rise, dn_lvl, dn_rise;
  logic count_up_ev, count_dn_ev;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .rst(rst), .strobe_in(up_strobe), .level(up_lvl), .rise(up_rise)
  );
  strobe_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk(clk), .rst(rst), .strobe_in(dn_strobe), .level(dn_lvl), .rise(dn_rise)
  );

  // steering: a rise counts only with the opposite strobe high; twin rises cancel
  assign count_up_ev = up_rise & dn_lvl & ~dn_rise;
  assign count_dn_ev = dn_rise & up_lvl & ~up_rise;

  count_core #(.BCD(BCD)) u_core (
    .clk(clk), .rst(rst), .clear(clear), .load_n(load_n), .din(din),
    .inc(count_up_ev), .dec(count_dn_ev), .q(q)
  );

  cascade_flags #(.BCD(BCD)) u_flags (
    .q(q), .up_lvl(up_lvl), .dn_lvl(dn_lvl), .carry_n(carry_n), .borrow_n(borrow_n)
  );
endmodule

// File: rtl/updn_checker.sv
`timescale 1ns/1ps
module updn_checker
  import updn_pkg::*;
#(
  parameter bit BCD = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       load_n,
  input logic       clear,
  input logic [3:0] din,
  input logic [3:0] q,
  input logic       carry_n,
  input logic       borrow_n,
  input logic       up_lvl,
  input logic       dn_lvl,
  input logic       count_up_ev,
  input logic       count_dn_ev
);
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (q == 4'd0)); // R5
  AST_LOAD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!clear && !load_n) |=> (q == $past(din))); // R4
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (count_up_ev && load_n && !clear) |=> (q == step_up($past(q), BCD))); // R1
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (count_dn_ev && load_n && !clear) |=> (q == step_down($past(q), BCD))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!count_up_ev && !count_dn_ev && load_n && !clear) |=> $stable(q)); // R3
  AST_NO_TWIN_EVENT: assert property (@(posedge clk) disable iff (rst)
    !(count_up_ev && count_dn_ev)); // R3
  AST_CARRY_QUIET: assert property (@(posedge clk) disable iff (rst)
    up_lvl |-> carry_n); // R6
  AST_BORROW_QUIET: assert property (@(posedge clk) disable iff (rst)
    dn_lvl |-> borrow_n); // R7
endmodule

bind updown_strobe_counter updn_checker #(.BCD(BCD)) u_chk (
  .clk(clk), .rst(rst), .load_n(load_n), .clear(clear), .din(din), .q(q),
  .carry_n(carry_n), .borrow_n(borrow_n), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
  .count_up_ev(count_up_ev), .count_dn_ev(count_dn_ev)
);

// File: tb/sim_updown_strobe_counter.sv
`timescale 1ns/1ps
module sim_updown_strobe_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up = 1'b1, dn = 1'b1, load_n = 1'b1, clear = 1'b0;
  logic [3:0] din0 = '0, din1 = '0;
  logic [3:0] q0, q1;
  logic cy0, bw0, cy1, bw1;
  logic cup = 1'b1, cdn = 1'b1;
  logic [3:0] cb0, cb1, cd0, cd1;
  logic cb0_cy, cb0_bw, cb1_cy, cb1_bw, cd0_cy, cd0_bw, cd1_cy, cd1_bw;
  int total = 0, bad = 0;
  int m0, m1, cbin, cdec;
  bit done = 0;

  always #2.5 clk = ~clk;

  updown_strobe_counter #(.BCD(1'b0)) u0 (.clk(clk), .rst(rst), .up_strobe(up), .dn_strobe(dn),
    .load_n(load_n), .clear(clear), .din(din0), .q(q0), .carry_n(cy0), .borrow_n(bw0));
  updown_strobe_counter #(.BCD(1'b1)) u1 (.clk(clk), .rst(rst), .up_strobe(up), .dn_strobe(dn),
    .load_n(load_n), .clear(clear), .din(din1), .q(q1), .carry_n(cy1), .borrow_n(bw1));

  // two-stage chains, binary and decimal
  updown_strobe_counter #(.BCD(1'b0)) ub_lo (.clk(clk), .rst(rst), .up_strobe(cup), .dn_strobe(cdn),
    .load_n(1'b1), .clear(1'b0), .din(4'd0), .q(cb0), .carry_n(cb0_cy), .borrow_n(cb0_bw));
  updown_strobe_counter #(.BCD(1'b0)) ub_hi (.clk(clk), .rst(rst), .up_strobe(cb0_cy), .dn_strobe(cb0_bw),
    .load_n(1'b1), .clear(1'b0), .din(4'd0), .q(cb1), .carry_n(cb1_cy), .borrow_n(cb1_bw));
  updown_strobe_counter #(.BCD(1'b1)) ud_lo (.clk(clk), .rst(rst), .up_strobe(cup), .dn_strobe(cdn),
    .load_n(1'b1), .clear(1'b0), .din(4'd0), .q(cd0), .carry_n(cd0_cy), .borrow_n(cd0_bw));
  updown_strobe_counter #(.BCD(1'b1)) ud_hi (.clk(clk), .rst(rst), .up_strobe(cd0_cy), .dn_strobe(cd0_bw),
    .load_n(1'b1), .clear(1'b0), .din(4'd0), .q(cd1), .carry_n(cd1_cy), .borrow_n(cd1_bw));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mup(input int v, input int top);
    return (v >= top) ? 0 : v + 1;
  endfunction
  function automatic int mdn(input int v, input int top);
    return (v == 0) ? top : v - 1;
  endfunction

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_load(input int v0, input int v1);
    @(negedge clk);
    din0 = 4'(v0); din1 = 4'(v1); load_n = 1'b0;
    @(negedge clk);
    load_n = 1'b1;
    wait_n(1);
    m0 = v0; m1 = v1;
  endtask

  task automatic pulse_up();
    up = 1'b0; wait_n(4); up = 1'b1; wait_n(4);
  endtask
  task automatic pulse_dn();
    dn = 1'b0; wait_n(4); dn = 1'b1; wait_n(4);
  endtask

  task automatic check_both(input string req);
    chk(req, int'(q0), m0);
    chk(req, int'(q1), m1);
  endtask

  task automatic carry_width(input int w);
    int low0 = 0, low1 = 0;
    do_load(15, 9);
    up = 1'b0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk); if (!cy0) low0++; if (!cy1) low1++;
    end
    up = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); if (!cy0) low0++; if (!cy1) low1++;
    end
    chk("R6 carry width bin", low0, w);
    chk("R6 carry width bcd", low1, w);
    m0 = 0; m1 = 0;
    check_both("R6 wrap after carry");
  endtask

  task automatic borrow_width(input int w);
    int low0 = 0, low1 = 0;
    do_load(0, 0);
    dn = 1'b0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk); if (!bw0) low0++; if (!bw1) low1++;
    end
    dn = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); if (!bw0) low0++; if (!bw1) low1++;
    end
    chk("R7 borrow width bin", low0, w);
    chk("R7 borrow width bcd", low1, w);
    m0 = 15; m1 = 9;
    check_both("R7 wrap after borrow");
  endtask

  task automatic cas_up();
    cup = 1'b0; wait_n(4); cup = 1'b1; wait_n(8);
    cbin = (cbin + 1) % 256; cdec = (cdec + 1) % 100;
  endtask
  task automatic cas_dn();
    cdn = 1'b0; wait_n(4); cdn = 1'b1; wait_n(8);
    cbin = (cbin + 255) % 256; cdec = (cdec + 99) % 100;
  endtask
  task automatic cas_check(input string req);
    chk(req, int'(cb1) * 16 + int'(cb0), cbin);
    chk(req, int'(cd1) * 10 + int'(cd0), cdec);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
    m0 = 0; m1 = 0; cbin = 0; cdec = 0;
    check_both("R10 reset value");
    chk("R10 carry idle", int'(cy0 & cy1), 1);
    chk("R10 borrow idle", int'(bw0 & bw1), 1);

    // R4, R1, R2: every load value, then one step each way
    for (int v = 0; v < 16; v++) begin
      do_load(v, v);
      check_both("R4 load value");
      pulse_up();
      m0 = mup(m0, 15); m1 = mup(m1, 9);
      check_both("R1 step up from loaded");
      do_load(v, v);
      pulse_dn();
      m0 = mdn(m0, 15); m1 = mdn(m1, 9);
      check_both("R2 step down from loaded");
    end

    // R1 and R2: long runs through the wrap points
    do_load(0, 0);
    for (int i = 0; i < 20; i++) begin
      pulse_up(); m0 = mup(m0, 15); m1 = mup(m1, 9);
      check_both("R1 up run");
    end
    for (int i = 0; i < 20; i++) begin
      pulse_dn(); m0 = mdn(m0, 15); m1 = mdn(m1, 9);
      check_both("R2 down run");
    end

    // R3: up rise while down is low is ignored; releasing down then counts down
    do_load(5, 5);
    dn = 1'b0; wait_n(4);
    pulse_up();
    check_both("R3 up rise with down low");
    dn = 1'b1; wait_n(4);
    m0 = 4; m1 = 4;
    check_both("R2 down release counts");
    up = 1'b0; wait_n(4);
    pulse_dn();
    check_both("R3 down rise with up low");
    up = 1'b1; wait_n(4);
    m0 = 5; m1 = 5;
    check_both("R1 up release counts");
    // R3: simultaneous rises cancel
    up = 1'b0; dn = 1'b0; wait_n(4);
    up = 1'b1; dn = 1'b1; wait_n(4);
    check_both("R3 twin rise");

    // R4: strobes ignored while load is low
    @(negedge clk);
    din0 = 4'd12; din1 = 4'd12; load_n = 1'b0;
    pulse_up(); pulse_dn();
    m0 = 12; m1 = 12;
    check_both("R4 strobes during load");
    load_n = 1'b1; wait_n(2);
    check_both("R4 value kept after load");

    // R5: clear beats load and strobes
    @(negedge clk);
    clear = 1'b1; load_n = 1'b0; din0 = 4'd7; din1 = 4'd7;
    pulse_up();
    m0 = 0; m1 = 0;
    check_both("R5 clear priority");
    clear = 1'b0; load_n = 1'b1; wait_n(2);
    check_both("R5 after clear");

    // R8: latency of three clock edges
    do_load(4, 4);
    up = 1'b0; wait_n(4);
    up = 1'b1;
    wait_n(2);
    check_both("R8 unchanged before third edge");
    wait_n(1);
    m0 = 5; m1 = 5;
    check_both("R8 changed at third edge");

    // R6 and R7: flag widths
    carry_width(3);
    carry_width(7);
    borrow_width(1);
    borrow_width(5);

    // R9: cascades
    for (int i = 0; i < 300; i++) begin
      cas_up();
      cas_check("R9 cascade up");
    end
    for (int i = 0; i < 60; i++) begin
      cas_dn();
      cas_check("R9 cascade down");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule